// File: doc/BRIEF.md
# PCI Special Cycle Monitor

This block listens, without driving any bus signal except a target-ready strobe, to a 32-bit PCI bus and picks out special-cycle transactions. Of the message codes a special cycle can carry, two are acted upon. A Shutdown message produces a single-clock system-management interrupt request (a warm-reset SMI) a fixed number of PCI clocks after the message is seen. A Halt message is answered by driving TRDY# low for one clock, so that the initiator sees the cycle complete.

Special cycles have no destination, so nothing from them is ever passed on to a downstream bus, and the block has no forwarding path at all. Every other message code is ignored. The block's outputs are the SMI request and an enable/value pair for the shared, tri-stated TRDY# line.

Top module: `pci_special_cycle_monitor`

## Requirements
- R1: During and right after reset `smi_req` is 0, `trdy_oe` is 0 and `trdy_out_n` is 1.
- R2: The address phase is the first rising edge at which `frame_n` is sampled 0 after an edge at which both `frame_n` and `irdy_n` were sampled 1. A transaction is a special cycle only when `cbe_n` equals 4'b0001 at that edge; any other command makes the block ignore the transaction's data.
- R3: The data phase of a special cycle is the first rising edge after the address phase at which `irdy_n` is sampled 0. Only that one edge is decoded; later data phases of the same transaction are not.
- R4: A message is decoded only when `cbe_n[1:0]` is 2'b00 in the data phase; with either of those two lanes disabled the data is ignored.
- R5: Shutdown is data `ad[15:0]` = 16'h0000 and Halt is `ad[15:0]` = 16'h0001; `ad[31:16]` and `cbe_n[3:2]` in the data phase do not affect decoding.
- R6: If Shutdown is decoded at rising edge k, `smi_req` is 1 from edge k+3 to edge k+4 and 0 otherwise (three clocks after detection, one clock wide).
- R7: A Shutdown decoded while an earlier Shutdown delay is still counting restarts the delay; only one `smi_req` pulse results, three clocks after the later message.
- R8: If Halt is decoded at edge k, the block drives TRDY# low (`trdy_oe`=1, `trdy_out_n`=0) from edge k to k+1, drives it high (`trdy_oe`=1, `trdy_out_n`=1) from k+1 to k+2, and releases it (`trdy_oe`=0) from k+2.
- R9: Any other message code raises neither `smi_req` nor `trdy_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| cbe_n | input | 4 | Bus command / byte enables, active low lanes |
| ad | input | 32 | Bus address/data |
| smi_req | output | 1 | One-clock warm-reset SMI request after Shutdown |
| trdy_oe | output | 1 | Output enable for the TRDY# driver |
| trdy_out_n | output | 1 | Value driven on TRDY# while enabled |

## Verification
A wrong phase flag shows up as a reaction to a transaction that is not a special cycle, or as no reaction to one, within one clock of the data phase for Halt and within four clocks for Shutdown. A delay counter that loads, counts or reloads wrongly moves or duplicates the `smi_req` pulse, which the bench sees by sampling every clock from the data phase to past the expected pulse. A faulty Halt sequencer shows as a TRDY# drive that is too long, too short or never released within three clocks of the data phase.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int AD_W  = 32;
  localparam int CBE_W = 4;
  localparam int MSG_W = 16;

  localparam logic [CBE_W-1:0] CMD_SPECIAL  = 4'b0001;
  localparam logic [MSG_W-1:0] MSG_SHUTDOWN = 16'h0000;
  localparam logic [MSG_W-1:0] MSG_HALT     = 16'h0001;

  typedef enum logic [1:0] {
    SC_NONE     = 2'd0,
    SC_SHUTDOWN = 2'd1,
    SC_HALT     = 2'd2
  } sc_msg_e;

  // Command field in the address phase names a special cycle
  function automatic logic is_special_cmd(input logic [CBE_W-1:0] cmd_n);
    return cmd_n == CMD_SPECIAL;
  endfunction

  // Both low byte lanes enabled (active-low)
  function automatic logic low_lanes_on(input logic [CBE_W-1:0] be_n);
    return be_n[1:0] == 2'b00;
  endfunction

  // Map the low half of the data word to a message kind
  function automatic sc_msg_e classify(input logic [MSG_W-1:0] code);
    if (code == MSG_SHUTDOWN) return SC_SHUTDOWN;
    if (code == MSG_HALT)     return SC_HALT;
    return SC_NONE;
  endfunction

endpackage

// File: rtl/sc_phase_track.sv
module sc_phase_track
  import sc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [CBE_W-1:0] cbe_n,
  output logic             addr_phase,
  output logic             data_phase
);

  logic idle_q;
  logic special_q;

  // Address phase: FRAME# low right after an idle edge
  assign addr_phase = idle_q && !frame_n;
  // First data phase of a recognised special cycle
  assign data_phase = special_q && !irdy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q    <= 1'b0;
      special_q <= 1'b0;
    end else begin
      idle_q <= frame_n && irdy_n;
      if (addr_phase)
        special_q <= is_special_cmd(cbe_n);
      else if (data_phase || (frame_n && irdy_n))
        special_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_msg_decode.sv
module sc_msg_decode
  import sc_pkg::*;
(
  input  logic             data_phase,
  input  logic [CBE_W-1:0] cbe_n,
  input  logic [MSG_W-1:0] msg,
  output logic             det_shutdown,
  output logic             det_halt
);

  sc_msg_e kind;

  always_comb begin
    kind = SC_NONE;
    if (data_phase && low_lanes_on(cbe_n))
      kind = classify(msg);
  end

  assign det_shutdown = (kind == SC_SHUTDOWN);
  assign det_halt     = (kind == SC_HALT);

endmodule

// File: rtl/sc_smi_delay.sv
module sc_smi_delay #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse
);

  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      // A fresh start wins over a count about to expire
      pulse <= (cnt == LAST) && !start;
      if (start)
        cnt <= LOAD;
      else if (cnt != '0)
        cnt <= cnt - LAST;
    end
  end

endmodule

// File: rtl/sc_halt_ack.sv
module sc_halt_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic drive_en,
  output logic drive_n
);

  typedef enum logic [1:0] {
    HA_IDLE = 2'd0,
    HA_LOW  = 2'd1,
    HA_HIGH = 2'd2
  } ha_state_e;

  ha_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= HA_IDLE;
    end else begin
      unique case (state)
        HA_IDLE: if (start) state <= HA_LOW;
        HA_LOW:  state <= HA_HIGH;
        HA_HIGH: state <= start ? HA_LOW : HA_IDLE;
        default: state <= HA_IDLE;
      endcase
    end
  end

  assign drive_en = (state != HA_IDLE);
  assign drive_n  = (state != HA_LOW);

endmodule

// File: rtl/pci_special_cycle_monitor.sv
module pci_special_cycle_monitor
  import sc_pkg::*;
#(
  parameter int SMI_DELAY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad,
  output logic        smi_req,
  output logic        trdy_oe,
  output logic        trdy_out_n
);

  logic addr_phase;
  logic data_phase;
  logic det_shutdown;
  logic det_halt;

  // Address bits and the high data half carry nothing this block uses
  logic unused_ad;
  assign unused_ad = ^ad[AD_W-1:MSG_W];

  sc_phase_track u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .cbe_n      (cbe_n),
    .addr_phase (addr_phase),
    .data_phase (data_phase)
  );

  sc_msg_decode u_decode (
    .data_phase   (data_phase),
    .cbe_n        (cbe_n),
    .msg          (ad[MSG_W-1:0]),
    .det_shutdown (det_shutdown),
    .det_halt     (det_halt)
  );

  sc_smi_delay #(.DELAY(SMI_DELAY)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .start (det_shutdown),
    .pulse (smi_req)
  );

  sc_halt_ack u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (det_halt),
    .drive_en (trdy_oe),
    .drive_n  (trdy_out_n)
  );

endmodule

// File: rtl/sc_monitor_checker.sv
module sc_monitor_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_phase,
  input logic       data_phase,
  input logic       det_shutdown,
  input logic       det_halt,
  input logic [3:0] cbe_n,
  input logic       smi_req,
  input logic       trdy_oe,
  input logic       trdy_out_n
);

  // R1: outputs quiet while reset is held
  always @(negedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!smi_req && !trdy_oe && trdy_out_n);

  // R9: at most one message kind per edge, and only in a data phase
  assert_one_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_shutdown || det_halt) |-> (data_phase && $onehot0({det_shutdown, det_halt})));

  // R4: no decode with a low lane disabled
  assert_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (det_shutdown || det_halt) |-> (cbe_n[1:0] == 2'b00));

  // R2: a data phase never coincides with an address phase
  assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> !data_phase);

  // R6: the request is one clock wide
  assert_smi_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |=> !smi_req);

  // R6/R7: the request always traces back to a Shutdown four samples earlier
  assert_smi_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> ($past(det_shutdown, 4) && !$past(det_shutdown, 3)
                 && !$past(det_shutdown, 2) && !$past(det_shutdown, 1)));

  // R8: Halt drives TRDY# low next clock
  assert_halt_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    det_halt |=> (trdy_oe && !trdy_out_n));

  // R8: low drive lasts one clock, then high drive
  assert_halt_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_out_n) |=> (trdy_oe && trdy_out_n));

  // R8: released one clock after the high drive unless a new Halt arrived
  assert_halt_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && trdy_out_n && !det_halt) |=> !trdy_oe);

  // R9: TRDY# drive only starts because of a Halt
  assert_halt_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy_oe) |-> $past(det_halt));

endmodule

bind pci_special_cycle_monitor sc_monitor_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_phase   (addr_phase),
  .data_phase   (data_phase),
  .det_shutdown (det_shutdown),
  .det_halt     (det_halt),
  .cbe_n        (cbe_n),
  .smi_req      (smi_req),
  .trdy_oe      (trdy_oe),
  .trdy_out_n   (trdy_out_n)
);

// File: tb/tb_pci_special_cycle_monitor.sv
`timescale 1ns/1ps
module tb_pci_special_cycle_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad = '0;
  logic        smi_req;
  logic        trdy_oe;
  logic        trdy_out_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  pci_special_cycle_monitor dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .cbe_n      (cbe_n),
    .ad         (ad),
    .smi_req    (smi_req),
    .trdy_oe    (trdy_oe),
    .trdy_out_n (trdy_out_n)
  );

  task automatic check(input string req, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual {smi,oe,out_n}=%b expected %b at %0t",
               req, what, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] outs();
    return {smi_req, trdy_oe, trdy_out_n};
  endfunction

  // Address phase then one data phase; returns at the negedge after the data edge (n1)
  task automatic transact(input logic [3:0] cmd, input logic [3:0] be,
                          input logic [31:0] data);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad = 32'hDEAD_0000;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = be; ad = data;
    @(negedge clk);
    irdy_n = 1'b1; cbe_n = 4'hF; ad = '0;
  endtask

  // Expect nothing for n1..n6
  task automatic expect_quiet(input string req, input string what);
    check(req, what, outs(), 3'b001);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(req, what, outs(), 3'b001);
    end
  endtask

  task automatic expect_shutdown(input string req, input string what);
    for (int n = 1; n <= 5; n++) begin
      if (n > 1) @(negedge clk);
      check(req, what, outs(), (n == 4) ? 3'b101 : 3'b001);
    end
  endtask

  task automatic t_reset();
    repeat (6) @(negedge clk);
    check("R1", "during reset", outs(), 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after reset", outs(), 3'b001);
  endtask

  task automatic t_shutdown_basic();
    transact(4'b0001, 4'b0000, 32'h0000_0000);
    expect_shutdown("R6", "shutdown pulse at third clock");
  endtask

  task automatic t_shutdown_upper_ignored();
    transact(4'b0001, 4'b1100, 32'hABCD_0000);
    expect_shutdown("R5", "shutdown with upper half and upper lanes don't-care");
  endtask

  task automatic t_halt();
    transact(4'b0001, 4'b0000, 32'h5A5A_0001);
    check("R8", "halt drive low", outs(), 3'b010);
    @(negedge clk);
    check("R8", "halt drive high", outs(), 3'b011);
    @(negedge clk);
    check("R8", "halt released", outs(), 3'b001);
    @(negedge clk);
    check("R8", "halt stays released", outs(), 3'b001);
  endtask

  task automatic t_other_code();
    transact(4'b0001, 4'b0000, 32'h0000_0002);
    expect_quiet("R9", "message 0002 ignored");
    transact(4'b0001, 4'b0000, 32'h0001_0100);
    expect_quiet("R9", "message 0100 ignored");
  endtask

  task automatic t_not_special();
    transact(4'b0110, 4'b0000, 32'h0000_0000);
    expect_quiet("R2", "memory read carrying shutdown code ignored");
    transact(4'b0111, 4'b0000, 32'h0000_0001);
    expect_quiet("R2", "memory write carrying halt code ignored");
  endtask

  task automatic t_lanes_off();
    transact(4'b0001, 4'b0001, 32'h0000_0000);
    expect_quiet("R4", "shutdown with lane 0 off ignored");
    transact(4'b0001, 4'b0010, 32'h0000_0001);
    expect_quiet("R4", "halt with lane 1 off ignored");
  endtask

  // Wait states then burst: only the first IRDY# low edge is decoded
  task automatic t_first_data_only();
    @(negedge clk);
    frame_n = 1'b0; cbe_n = 4'b0001; ad = '0;
    @(negedge clk);
    cbe_n = 4'b0000; ad = 32'h0000_0002;  // wait state, IRDY# high, FRAME# still low
    check("R3", "no reaction before data phase", outs(), 3'b001);
    @(negedge clk);
    irdy_n = 1'b0;                        // first data phase: unknown code
    @(negedge clk);
    ad = 32'h0000_0001;                   // second data phase carries halt code
    frame_n = 1'b1;
    @(negedge clk);
    irdy_n = 1'b1; cbe_n = 4'hF; ad = '0;
    check("R3", "second data phase not decoded", outs(), 3'b001);
    @(negedge clk);
    check("R3", "still no drive", outs(), 3'b001);
  endtask

  // Second shutdown lands on the edge where the first would expire
  task automatic t_restart();
    @(negedge clk);
    frame_n = 1'b0; cbe_n = 4'b0001; ad = '0;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'b0000; ad = 32'h0000_0000;
    @(negedge clk);                       // n1 of first, idle edge next
    irdy_n = 1'b1; cbe_n = 4'hF;
    check("R7", "first n1", outs(), 3'b001);
    @(negedge clk);                       // n2: drive second address
    check("R7", "first n2", outs(), 3'b001);
    frame_n = 1'b0; cbe_n = 4'b0001;
    @(negedge clk);                       // n3: drive second data
    check("R7", "first n3", outs(), 3'b001);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'b0000; ad = 32'hFFFF_0000;
    @(negedge clk);                       // first n4 == second n1
    irdy_n = 1'b1; cbe_n = 4'hF; ad = '0;
    check("R7", "first pulse suppressed", outs(), 3'b001);
    @(negedge clk);
    check("R7", "second n2", outs(), 3'b001);
    @(negedge clk);
    check("R7", "second n3", outs(), 3'b001);
    @(negedge clk);
    check("R7", "single pulse after restart", outs(), 3'b101);
    @(negedge clk);
    check("R7", "pulse ends", outs(), 3'b001);
    @(negedge clk);
    check("R7", "no second pulse", outs(), 3'b001);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_shutdown_basic();
    t_shutdown_upper_ignored();
    t_halt();
    t_other_code();
    t_not_special();
    t_lanes_off();
    t_first_data_only();
    repeat (6) @(negedge clk);
    t_restart();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule